// File: doc/BRIEF.md
# Banked RAM Window Mirroring Translator

This block turns a CPU word address into a physical word index for a main-memory array built from banks of two sizes. The RAM address range is cut into four windows of 4M words (16 MB) each. A window holds either a large bank that fills it, a small bank of 1M words (4 MB) that repeats four times across it, or nothing. The installed memory is given as two counts, the number of large banks and the number of small banks. Large banks take the lowest windows and small banks the windows above them. Each bank's physical base sits directly after the banks below it, so the physical array has no holes.

The counts are captured once after reset into a per-window table of base and offset mask. Each request is translated in one registered stage. An address below the populated limit drives an enable, an index, byte enables and write data to the memory port. Any other address is reported as a no-RAM access and leaves the memory untouched.

Top module: `bank_mirror_xlat`

## Requirements
- R1: On the first rising clock edge after `rst_ni` is released, the block captures `cfg_large_i` and `cfg_small_i`. The large count is clamped to 4 and the small count to 4 minus the clamped large count. The captured map then holds until the next reset, whatever the configuration inputs do.
- R2: The window is selected by word-address bits [23:22]. A window holding a large bank maps its offset through mask 0x3FFFFF.
- R3: A window holding a small bank maps its offset through mask 0x0FFFFF. Addresses that differ only in bits [21:20] reach the same physical word.
- R4: Physical bases are packed in window order. A large bank counts 0x400000 words and a small bank 0x100000 words, so each base is the sum of the sizes of all lower populated windows.
- R5: An access is a hit exactly when the word address is below (large + small) × 0x400000. Otherwise `rsp_noram_o` is asserted and `rsp_hit_o` is low.
- R6: On a miss, `mem_en_o` and `mem_we_o` stay low, `mem_idx_o` is zero and `rsp_rdata_o` is zero.
- R7: A request presented at a clock edge produces its response, including `rsp_valid_o`, the memory port fields and the `mem_idx_o` value (base + (address AND mask)), in the cycle after that edge. For a hit read, `rsp_rdata_o` equals `mem_rdata_i` in that cycle. With no request, nothing is valid.
- R8: For a hit, `mem_we_o` equals the request's write flag, and `mem_be_o` and `mem_wdata_o` carry the request's byte enables and data. Bit i of `mem_be_o` enables byte lane i (data bits 8i+7 down to 8i), so only the enabled lanes of the target word change.
- R9: While `rst_ni` is low, `rsp_valid_o`, `rsp_hit_o`, `rsp_noram_o` and `mem_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_large_i | input | 3 | Count of 16 MB banks |
| cfg_small_i | input | 3 | Count of 4 MB banks |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | Request is a write |
| req_addr_i | input | 32 | Word address |
| req_be_i | input | 4 | Byte-lane enables |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Response reached RAM |
| rsp_noram_o | output | 1 | Response fell outside RAM |
| rsp_rdata_o | output | 32 | Read data, zero on miss |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_idx_o | output | 24 | Physical word index |
| mem_be_o | output | 4 | Byte-lane enables to memory |
| mem_wdata_o | output | 32 | Write data to memory |
| mem_rdata_i | input | 32 | Read data from memory |

## Verification
The assertions check every cycle that a response follows each request after one stage, and that hit and no-RAM exclude each other. They also check that a miss never enables the memory and returns zero data, that no hit comes from above the four-window ceiling, and that write strobes, lanes and data track the request. Only the bench scenarios can show the address arithmetic itself: the base packing for each mix of bank counts, mirroring inside small windows, the exact populated limit, clamping of oversized counts, lane merging in the stored word, and that the map holds after the configuration inputs change.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  parameter int unsigned ADDR_W   = 32;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned N_SETS   = 4;
  parameter int unsigned LG_OFS_W = 22;
  parameter int unsigned SM_OFS_W = 20;

  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_MISS = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/bxl_set_table.sv
module bxl_set_table #(
  parameter int unsigned N_SETS   = 4,
  parameter int unsigned LG_OFS_W = 22,
  parameter int unsigned SM_OFS_W = 20,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned IDX_W    = 24,
  parameter int unsigned LIM_W    = 25
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    cfg_large_i,
  input  logic [CNT_W-1:0]    cfg_small_i,
  output logic [IDX_W-1:0]    base_o [N_SETS],
  output logic [LG_OFS_W-1:0] mask_o [N_SETS],
  output logic [LIM_W-1:0]    limit_o
);
  localparam logic [CNT_W-1:0]    SETS_C  = CNT_W'(N_SETS);
  localparam logic [LG_OFS_W-1:0] LG_MASK = '1;
  localparam logic [LG_OFS_W-1:0] SM_MASK = {{(LG_OFS_W-SM_OFS_W){1'b0}}, {SM_OFS_W{1'b1}}};

  logic [CNT_W-1:0]    n_lg, n_sm, n_pop;
  logic [IDX_W-1:0]    base_d [N_SETS];
  logic [LG_OFS_W-1:0] mask_d [N_SETS];
  logic [LIM_W-1:0]    limit_d;
  logic                loaded_q;

  // clamp: large banks fill first, small banks take what is left
  always_comb begin
    n_lg  = (cfg_large_i > SETS_C) ? SETS_C : cfg_large_i;
    n_sm  = (cfg_small_i > (SETS_C - n_lg)) ? (SETS_C - n_lg) : cfg_small_i;
    n_pop = n_lg + n_sm;
    limit_d = LIM_W'(n_pop) << LG_OFS_W;
  end

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    localparam logic [CNT_W-1:0] SI = CNT_W'(s);

    always_comb begin
      if (SI < n_lg) begin
        base_d[s] = IDX_W'(SI) << LG_OFS_W;
        mask_d[s] = LG_MASK;
      end else if (SI < n_pop) begin
        base_d[s] = (IDX_W'(n_lg) << LG_OFS_W) + (IDX_W'(SI - n_lg) << SM_OFS_W);
        mask_d[s] = SM_MASK;
      end else begin
        base_d[s] = '0;
        mask_d[s] = '0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[s] <= '0;
        mask_o[s] <= '0;
      end else if (!loaded_q) begin
        base_o[s] <= base_d[s];
        mask_o[s] <= mask_d[s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      limit_o  <= '0;
    end else if (!loaded_q) begin
      loaded_q <= 1'b1;
      limit_o  <= limit_d;
    end
  end
endmodule

// File: rtl/bxl_window_map.sv
module bxl_window_map #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned N_SETS   = 4,
  parameter int unsigned LG_OFS_W = 22,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned IDX_W    = 24,
  parameter int unsigned LIM_W    = 25
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [IDX_W-1:0]    base_i [N_SETS],
  input  logic [LG_OFS_W-1:0] mask_i [N_SETS],
  input  logic [LIM_W-1:0]    limit_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [SEL_W-1:0]    sel;
  logic [LG_OFS_W-1:0] ofs;

  always_comb begin
    sel   = addr_i[LG_OFS_W +: SEL_W];
    ofs   = addr_i[LG_OFS_W-1:0] & mask_i[sel];
    hit_o = addr_i < {{(ADDR_W-LIM_W){1'b0}}, limit_i};
    idx_o = base_i[sel] + {{SEL_W{1'b0}}, ofs};
  end
endmodule

// File: rtl/bxl_req_pipe.sv
module bxl_req_pipe
  import bxl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4,
  parameter int unsigned IDX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_noram_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  rsp_kind_e         kind_q;
  logic              we_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= RSP_IDLE;
      we_q    <= 1'b0;
      idx_q   <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      if (!valid_i)   kind_q <= RSP_IDLE;
      else if (hit_i) kind_q <= RSP_HIT;
      else            kind_q <= RSP_MISS;
      we_q    <= valid_i & we_i;
      idx_q   <= (valid_i & hit_i) ? idx_i : '0;
      be_q    <= be_i;
      wdata_q <= wdata_i;
    end
  end

  always_comb begin
    rsp_valid_o = kind_q != RSP_IDLE;
    rsp_hit_o   = kind_q == RSP_HIT;
    rsp_noram_o = kind_q == RSP_MISS;
    mem_en_o    = rsp_hit_o;
    mem_we_o    = rsp_hit_o & we_q;
    mem_idx_o   = idx_q;
    mem_be_o    = be_q;
    mem_wdata_o = wdata_q;
    rsp_rdata_o = (rsp_hit_o && !we_q) ? mem_rdata_i : '0;
  end
endmodule

// File: rtl/bank_mirror_xlat.sv
module bank_mirror_xlat
  import bxl_pkg::*;
#(
  parameter int unsigned ADDR_W   = bxl_pkg::ADDR_W,
  parameter int unsigned DATA_W   = bxl_pkg::DATA_W,
  parameter int unsigned N_SETS   = bxl_pkg::N_SETS,
  parameter int unsigned LG_OFS_W = bxl_pkg::LG_OFS_W,
  parameter int unsigned SM_OFS_W = bxl_pkg::SM_OFS_W,
  localparam int unsigned CNT_W   = $clog2(N_SETS + 1),
  localparam int unsigned SEL_W   = $clog2(N_SETS),
  localparam int unsigned IDX_W   = LG_OFS_W + SEL_W,
  localparam int unsigned LIM_W   = IDX_W + 1,
  localparam int unsigned BE_W    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cfg_large_i,
  input  logic [CNT_W-1:0]  cfg_small_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_noram_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [IDX_W-1:0]    set_base [N_SETS];
  logic [LG_OFS_W-1:0] set_mask [N_SETS];
  logic [LIM_W-1:0]    pop_limit;
  logic                map_hit;
  logic [IDX_W-1:0]    map_idx;

  bxl_set_table #(
    .N_SETS(N_SETS), .LG_OFS_W(LG_OFS_W), .SM_OFS_W(SM_OFS_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .LIM_W(LIM_W)
  ) i_set_table (
    .clk_i, .rst_ni, .cfg_large_i, .cfg_small_i,
    .base_o(set_base), .mask_o(set_mask), .limit_o(pop_limit)
  );

  bxl_window_map #(
    .ADDR_W(ADDR_W), .N_SETS(N_SETS), .LG_OFS_W(LG_OFS_W),
    .SEL_W(SEL_W), .IDX_W(IDX_W), .LIM_W(LIM_W)
  ) i_window_map (
    .addr_i(req_addr_i), .base_i(set_base), .mask_i(set_mask),
    .limit_i(pop_limit), .hit_o(map_hit), .idx_o(map_idx)
  );

  bxl_req_pipe #(
    .DATA_W(DATA_W), .BE_W(BE_W), .IDX_W(IDX_W)
  ) i_req_pipe (
    .clk_i, .rst_ni,
    .valid_i(req_valid_i), .we_i(req_we_i), .hit_i(map_hit), .idx_i(map_idx),
    .be_i(req_be_i), .wdata_i(req_wdata_i), .mem_rdata_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_noram_o, .rsp_rdata_o,
    .mem_en_o, .mem_we_o, .mem_idx_o, .mem_be_o, .mem_wdata_o
  );
endmodule

// File: rtl/bxl_checker.sv
module bxl_checker #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_SETS   = 4,
  parameter int unsigned LG_OFS_W = 22,
  localparam int unsigned BE_W    = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [BE_W-1:0]   req_be_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_noram_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [BE_W-1:0]   mem_be_o,
  input logic [DATA_W-1:0] mem_wdata_o
);
  localparam logic [ADDR_W-1:0] CAP = ADDR_W'(N_SETS) << LG_OFS_W;

  AST_REQ_TO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R7
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !mem_en_o)); // R7
  AST_HIT_XOR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o != rsp_noram_o)); // R5
  AST_HIT_BELOW_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> ($past(req_addr_i) < CAP)); // R5
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_noram_o |-> (!mem_en_o && !mem_we_o && rsp_rdata_o == '0)); // R6
  AST_WE_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (mem_we_o == $past(req_we_i))); // R8
  AST_LANES_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_be_o == $past(req_be_i) && mem_wdata_o == $past(req_wdata_i))); // R8

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!rsp_valid_o && !rsp_hit_o && !rsp_noram_o && !mem_en_o); // R9
    end
  end
endmodule

bind bank_mirror_xlat bxl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SETS(N_SETS), .LG_OFS_W(LG_OFS_W)
) i_bxl_checker (
  .clk_i, .rst_ni, .req_valid_i, .req_we_i, .req_addr_i, .req_be_i, .req_wdata_i,
  .rsp_valid_o, .rsp_hit_o, .rsp_noram_o, .rsp_rdata_o,
  .mem_en_o, .mem_we_o, .mem_be_o, .mem_wdata_o
);

// File: tb/test_bank_mirror_xlat.sv
`timescale 1ns/1ps
module test_bank_mirror_xlat;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cfg_large = '0, cfg_small = '0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid, rsp_hit, rsp_noram, mem_en, mem_we;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [23:0] mem_idx;
  logic [3:0]  mem_be;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 1'b0;
  logic [31:0] mem [int unsigned];

  logic        s_valid, s_hit, s_noram, s_en, s_we;
  logic [31:0] s_idx, s_rdata, s_wdata;
  logic [3:0]  s_be;

  always #2.5 clk = ~clk;

  bank_mirror_xlat i_bank_mirror_xlat (
    .clk_i(clk), .rst_ni, .cfg_large_i(cfg_large), .cfg_small_i(cfg_small),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_noram_o(rsp_noram),
    .rsp_rdata_o(rsp_rdata), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_idx_o(mem_idx), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  // behavioural word memory with byte-lane merge
  initial mem_rdata = '0;
  always begin
    @(posedge clk);
    #1;
    mem_rdata = mem.exists(32'(mem_idx)) ? mem[32'(mem_idx)] : 32'h0;
  end
  always @(negedge clk) begin
    if (mem_we) begin
      logic [31:0] w;
      w = mem.exists(32'(mem_idx)) ? mem[32'(mem_idx)] : 32'h0;
      for (int b = 0; b < 4; b++) if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
      mem[32'(mem_idx)] = w;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] lg, input logic [2:0] sm);
    @(negedge clk);
    rst_ni = 1'b0; req_valid = 1'b0; cfg_large = lg; cfg_small = sm;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [31:0] addr,
                        input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_be = be; req_wdata = wd;
    @(negedge clk);
    s_valid = rsp_valid; s_hit = rsp_hit; s_noram = rsp_noram; s_en = mem_en;
    s_we = mem_we; s_idx = 32'(mem_idx); s_rdata = rsp_rdata; s_be = mem_be;
    s_wdata = mem_wdata;
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [31:0] addr, input logic [31:0] idx);
    access(1'b0, addr, 4'h0, 32'h0);
    chk({tag, " hit"}, 32'(s_hit), 32'd1);
    chk({tag, " idx"}, s_idx, idx);
  endtask

  task automatic expect_miss(input string tag, input logic [31:0] addr);
    access(1'b0, addr, 4'h0, 32'h0);
    chk({tag, " noram"}, 32'(s_noram), 32'd1);
    chk({tag, " hit"}, 32'(s_hit), 32'd0);
    chk({tag, " en"}, 32'(s_en), 32'd0);
    chk({tag, " idx"}, s_idx, 32'd0);
    chk({tag, " rdata"}, s_rdata, 32'd0);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_ni = 1'b0; req_valid = 1'b1; req_addr = 32'h10;
    repeat (2) @(negedge clk);
    chk("R9 valid in reset", 32'(rsp_valid), 32'd0);
    chk("R9 en in reset", 32'(mem_en), 32'd0);
    chk("R9 noram in reset", 32'(rsp_noram), 32'd0);
    req_valid = 1'b0;
  endtask

  task automatic t_mixed;  // one large, two small
    do_reset(3'd1, 3'd2);
    expect_hit("R2 large offset", 32'h0012_3456, 32'h12_3456);
    expect_hit("R4 first small base", 32'h0040_0010, 32'h40_0010);
    expect_hit("R3 small mirror", 32'h0050_0010, 32'h40_0010);
    expect_hit("R3 small mirror top", 32'h007F_FFFF, 32'h4F_FFFF);
    expect_hit("R4 second small base", 32'h0080_0005, 32'h50_0005);
    expect_hit("R3 second small mirror", 32'h00B0_0005, 32'h50_0005);
    expect_hit("R5 last word below limit", 32'h00BF_FFFF, 32'h5F_FFFF);
    expect_miss("R5 at limit", 32'h00C0_0000);
    expect_miss("R6 far above", 32'h0400_0000);
  endtask

  task automatic t_all_small;
    do_reset(3'd0, 3'd4);
    expect_hit("R4 small set3", 32'h00F0_0001, 32'h30_0001);
    expect_hit("R3 small set0 mirror", 32'h0030_0002, 32'h00_0002);
    expect_miss("R5 all small limit", 32'h0100_0000);
  endtask

  task automatic t_all_large;
    do_reset(3'd4, 3'd0);
    expect_hit("R2 large set3", 32'h00FF_FFFF, 32'hFF_FFFF);
    expect_hit("R2 large set2", 32'h0087_6543, 32'h87_6543);
    expect_miss("R5 all large limit", 32'h0100_0000);
  endtask

  task automatic t_empty;
    do_reset(3'd0, 3'd0);
    expect_miss("R5 empty addr0", 32'h0000_0000);
  endtask

  task automatic t_clamp;
    do_reset(3'd5, 3'd3);
    expect_hit("R1 clamp large", 32'h00FF_FFF0, 32'hFF_FFF0);
    do_reset(3'd2, 3'd4);
    expect_hit("R1 clamp small", 32'h00C0_0003, 32'h90_0003);
    expect_hit("R1 clamp small mirror", 32'h00F0_0003, 32'h90_0003);
    expect_miss("R1 clamp limit", 32'h0100_0000);
  endtask

  task automatic t_cfg_hold;
    do_reset(3'd1, 3'd2);
    cfg_large = 3'd4; cfg_small = 3'd0;
    repeat (3) @(negedge clk);
    expect_hit("R1 hold mirror", 32'h0060_0007, 32'h40_0007);
    expect_miss("R1 hold limit", 32'h00C0_0000);
  endtask

  task automatic t_write_merge;
    do_reset(3'd1, 3'd2);
    access(1'b1, 32'h0040_0020, 4'hF, 32'h1122_3344);
    chk("R8 we on hit write", 32'(s_we), 32'd1);
    chk("R8 wdata", s_wdata, 32'h1122_3344);
    access(1'b1, 32'h0070_0020, 4'b0010, 32'hAABB_CCDD);
    chk("R8 be", 32'(s_be), 32'h2);
    chk("R3 write alias idx", s_idx, 32'h40_0020);
    access(1'b0, 32'h0040_0020, 4'h0, 32'h0);
    chk("R8 lane merge", s_rdata, 32'h1122_CC44);
    chk("R7 read valid", 32'(s_valid), 32'd1);
    access(1'b1, 32'h00C0_0000, 4'hF, 32'hDEAD_BEEF);
    chk("R6 miss write we", 32'(s_we), 32'd0);
    chk("R6 miss write en", 32'(s_en), 32'd0);
  endtask

  task automatic t_latency;
    do_reset(3'd1, 3'd0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0100; req_we = 1'b0;
    #1;
    chk("R7 no same-cycle response", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R7 response next cycle", 32'(rsp_valid), 32'd1);
    chk("R7 idx next cycle", 32'(mem_idx), 32'h100);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R7 idle after request", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_mixed();
    t_all_small();
    t_all_large();
    t_empty();
    t_clamp();
    t_cfg_hold();
    t_write_merge();
    t_latency();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule